// File: doc/BRIEF.md
# Vector Loop State Register Unit

This unit holds the architectural state of a vector loop as one packed 32-bit status word. The word carries the maximum vector length (MVL), the current vector length (VL), the sub-vector group size (SUBVL), and the destination and source element step counters. Next to the live word the unit keeps two shadow copies. One is a trap-save copy that is exchanged with the live word when a trap is entered or left. The other is a link copy that a vectorised branch exchanges with the live word.

Software sets the vector length with a set-length request. The unit clamps the requested length to the current MVL, returns the granted value in the same cycle and stores it as VL at the next clock edge. A full context restore is a single write of the packed word. The unit checks the written MVL and SUBVL. A write with an out-of-range value is discarded and raises a one-cycle illegal-value flag. Any legal write that would leave VL above MVL is clamped, so VL never exceeds MVL.

The unit has no streamed data path. Every input is a plain strobe or a value that is taken in the cycle it is presented. There is no back-pressure: every request is accepted at once, and when several strobes arrive together a fixed priority chooses the one that acts.

Top module: `vls_state`

## Requirements
- R1: After reset the live, trap-save and link words all read 0x00004040 (MVL=64, VL=0, SUBVL=1, both steps 0), and `illegal_o` is low.
- R2: Word layout: MVL in bits [6:0], VL in bits [13:7], SUBVL as a plain value in bits [16:14], destination step in bits [23:17], source step in bits [30:24]. Bit 31 is reserved and always reads 0, whatever was written to it.
- R3: While `setvl_req` is high, `setvl_grant` equals min(`setvl_len`, current MVL) in that same cycle. At the next edge VL takes that value and every other field keeps its value.
- R4: VL never exceeds MVL. A legal write whose VL field is larger than its own MVL field stores VL equal to that MVL.
- R5: A write whose SUBVL field is 0, 5, 6 or 7 leaves all three words unchanged and drives `illegal_o` high for exactly the one cycle after the write edge.
- R6: A write whose MVL field is 0 or greater than 64 leaves all three words unchanged and drives `illegal_o` high for exactly the one cycle after the write edge.
- R7: A legal write replaces the whole live context (all five fields) at the next edge, and `illegal_o` stays low.
- R8: `trap_enter` or `trap_ret` exchanges the live and trap-save words at the next edge.
- R9: `branch_link` exchanges the live and link words at the next edge.
- R10: Priority, from highest to lowest: trap strobe, then `branch_link`, then `wr_en`, then `setvl_req`. Lower-priority requests in the same cycle are ignored, and an ignored write never raises `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setvl_req | input | 1 | Set-vector-length request strobe |
| setvl_len | input | REQ_W | Requested vector length |
| setvl_grant | output | 7 | Granted length, min(request, MVL) |
| wr_en | input | 1 | Write strobe for the packed word |
| wr_word | input | 32 | Packed word to write |
| live_word | output | 32 | Live status word |
| save_word | output | 32 | Trap-save copy |
| link_word | output | 32 | Link copy |
| trap_enter | input | 1 | Trap entry strobe |
| trap_ret | input | 1 | Trap return strobe |
| branch_link | input | 1 | Vectorised-branch link exchange strobe |
| illegal_o | output | 1 | Illegal-value flag, one-cycle pulse |

## Verification
`setvl_grant` is combinational, so the bench samples it in the same cycle as the request, before the clock edge. Each state change and the `illegal_o` pulse show one edge after the strobe. The bench drives its inputs on the falling edge and samples the three words and the flag on the next falling edge, so that one register stage lies between stimulus and check. A further falling-edge sample after an idle cycle confirms that the illegal pulse lasts a single cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int VLS_MAXVL = 64;
  localparam int VLS_LW    = $clog2(VLS_MAXVL + 1);
  localparam int VLS_SW    = 3;
  localparam int VLS_WW    = 32;
  localparam int VLS_MAXSUB = 4;

  // field order msb->lsb gives the packed word layout
  typedef struct packed {
    logic [VLS_LW-1:0] src;
    logic [VLS_LW-1:0] dst;
    logic [VLS_SW-1:0] sub;
    logic [VLS_LW-1:0] vl;
    logic [VLS_LW-1:0] mvl;
  } vls_state_t;

  localparam int VLS_SB = $bits(vls_state_t);

  function automatic logic [VLS_WW-1:0] vls_pack(input vls_state_t s);
    return {{(VLS_WW-VLS_SB){1'b0}}, s};
  endfunction

  function automatic vls_state_t vls_unpack(input logic [VLS_WW-1:0] w);
    return vls_state_t'(w[VLS_SB-1:0]);
  endfunction

  function automatic vls_state_t vls_reset_state();
    vls_state_t s;
    s     = '0;
    s.mvl = VLS_LW'(VLS_MAXVL);
    s.sub = VLS_SW'(1);
    return s;
  endfunction
endpackage

// File: rtl/vls_clamp.sv
module vls_clamp #(
  parameter int AW = 16,
  parameter int BW = 7
) (
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  output logic [BW-1:0] y
);
  localparam int W = (AW > BW) ? AW : BW;
  logic [W-1:0] ae, be;
  always_comb begin
    ae = W'(a);
    be = W'(b);
    y  = (ae < be) ? ae[BW-1:0] : b;
  end
endmodule

// File: rtl/vls_wdec.sv
module vls_wdec
  import vls_pkg::*;
(
  input  logic [VLS_WW-1:0] word,
  output vls_state_t        next,
  output logic              bad
);
  vls_state_t raw;
  logic [VLS_LW-1:0] vl_c;
  logic mvl_bad, sub_bad;
  logic unused_rsvd;

  assign raw         = vls_unpack(word);
  assign unused_rsvd = ^word[VLS_WW-1:VLS_SB];

  vls_clamp #(.AW(VLS_LW), .BW(VLS_LW)) u_vl_clamp (
    .a(raw.vl), .b(raw.mvl), .y(vl_c)
  );

  always_comb begin
    mvl_bad = (raw.mvl == '0) || (raw.mvl > VLS_LW'(VLS_MAXVL));
    sub_bad = (raw.sub == '0) || (raw.sub > VLS_SW'(VLS_MAXSUB));
    bad     = mvl_bad || sub_bad;
    next    = raw;
    next.vl = vl_c;
  end
endmodule

// File: rtl/vls_state.sv
module vls_state
  import vls_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                setvl_req,
  input  logic [REQ_W-1:0]    setvl_len,
  output logic [VLS_LW-1:0]   setvl_grant,
  input  logic                wr_en,
  input  logic [VLS_WW-1:0]   wr_word,
  output logic [VLS_WW-1:0]   live_word,
  output logic [VLS_WW-1:0]   save_word,
  output logic [VLS_WW-1:0]   link_word,
  input  logic                trap_enter,
  input  logic                trap_ret,
  input  logic                branch_link,
  output logic                illegal_o
);
  vls_state_t live_q, save_q, link_q;
  vls_state_t wr_next;
  logic       wr_bad;
  logic       ill_q;
  logic       do_trap, do_link, do_wr, do_setvl;

  vls_clamp #(.AW(REQ_W), .BW(VLS_LW)) u_grant (
    .a(setvl_len), .b(live_q.mvl), .y(setvl_grant)
  );

  vls_wdec u_wdec (
    .word(wr_word), .next(wr_next), .bad(wr_bad)
  );

  always_comb begin
    do_trap  = trap_enter | trap_ret;
    do_link  = !do_trap && branch_link;
    do_wr    = !do_trap && !branch_link && wr_en;
    do_setvl = !do_trap && !branch_link && !wr_en && setvl_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= vls_reset_state();
      save_q <= vls_reset_state();
      link_q <= vls_reset_state();
      ill_q  <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      if (do_trap) begin
        live_q <= save_q;
        save_q <= live_q;
      end else if (do_link) begin
        live_q <= link_q;
        link_q <= live_q;
      end else if (do_wr) begin
        if (wr_bad) ill_q  <= 1'b1;
        else        live_q <= wr_next;
      end else if (do_setvl) begin
        live_q.vl <= setvl_grant;
      end
    end
  end

  assign live_word = vls_pack(live_q);
  assign save_word = vls_pack(save_q);
  assign link_word = vls_pack(link_q);
  assign illegal_o = ill_q;
endmodule

// File: rtl/vls_state_chk.sv
module vls_state_chk
  import vls_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              setvl_req,
  input logic [REQ_W-1:0]  setvl_len,
  input logic [VLS_LW-1:0] setvl_grant,
  input logic              wr_en,
  input logic [VLS_WW-1:0] wr_word,
  input logic [VLS_WW-1:0] live_word,
  input logic [VLS_WW-1:0] save_word,
  input logic [VLS_WW-1:0] link_word,
  input logic              trap_enter,
  input logic              trap_ret,
  input logic              branch_link,
  input logic              illegal_o
);
  logic [6:0] l_mvl, l_vl, w_mvl;
  logic [2:0] w_sub;
  logic       w_bad, quiet_hi;
  assign l_mvl    = live_word[6:0];
  assign l_vl     = live_word[13:7];
  assign w_mvl    = wr_word[6:0];
  assign w_sub    = wr_word[16:14];
  assign w_bad    = (w_mvl == 0) || (w_mvl > 7'd64) || (w_sub == 0) || (w_sub > 3'd4);
  assign quiet_hi = !trap_enter && !trap_ret && !branch_link;

  a_r4_vl_le_mvl: assert property (@(posedge clk) disable iff (!rst_n)
    l_vl <= l_mvl);

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !live_word[31] && !save_word[31] && !link_word[31]);

  a_r3_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
    setvl_req |-> (setvl_grant <= l_mvl) && (REQ_W'(setvl_grant) <= setvl_len));

  a_r5_r6_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && quiet_hi && w_bad) |=> illegal_o && $stable(live_word));

  a_r8_trap_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_enter || trap_ret) |=> (live_word == $past(save_word)) && (save_word == $past(live_word)));

  a_r9_link_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_link && !trap_enter && !trap_ret) |=> (live_word == $past(link_word)) && (link_word == $past(live_word)));

  a_r10_no_spurious_ill: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && quiet_hi) |=> !illegal_o);
endmodule

bind vls_state vls_state_chk #(.REQ_W(REQ_W)) u_chk (.*);

// File: tb/tb_vls_state.sv
module tb_vls_state;
  localparam int CLK_P = 10;
  localparam int REQ_W = 16;
  localparam int NV    = 11;

  function automatic logic [31:0] mk(input int mvl, input int vl, input int sub, input int dst, input int src);
    return {1'b0, 7'(src), 7'(dst), 3'(sub), 7'(vl), 7'(mvl)};
  endfunction

  localparam logic [31:0] RST_W = 32'h0000_4040;

  // op: 0 = write, 1 = set-length
  localparam int          V_OP  [NV] = '{0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam logic [31:0] V_ARG [NV] = '{
    mk(32,10,2,3,4), 32'd100, 32'd5, mk(16,5,0,0,0), mk(8,20,4,1,1),
    mk(0,0,1,0,0), mk(65,0,1,0,0), mk(64,64,3,0,0), 32'd0,
    mk(20,3,1,2,2) | 32'h8000_0000, mk(20,3,5,2,2)};
  localparam logic [31:0] V_EXP [NV] = '{
    mk(32,10,2,3,4), mk(32,32,2,3,4), mk(32,5,2,3,4), mk(32,5,2,3,4), mk(8,8,4,1,1),
    mk(8,8,4,1,1), mk(8,8,4,1,1), mk(64,64,3,0,0), mk(64,0,3,0,0),
    mk(20,3,1,2,2), mk(20,3,1,2,2)};
  localparam bit          V_ILL [NV] = '{0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 1};
  localparam int          V_GR  [NV] = '{0, 32, 5, 0, 0, 0, 0, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setvl_req = 1'b0;
  logic [REQ_W-1:0] setvl_len = '0;
  logic [6:0] setvl_grant;
  logic wr_en = 1'b0;
  logic [31:0] wr_word = '0;
  logic [31:0] live_word, save_word, link_word;
  logic trap_enter = 1'b0, trap_ret = 1'b0, branch_link = 1'b0;
  logic illegal_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  vls_state #(.REQ_W(REQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .setvl_req(setvl_req), .setvl_len(setvl_len),
    .setvl_grant(setvl_grant), .wr_en(wr_en), .wr_word(wr_word),
    .live_word(live_word), .save_word(save_word), .link_word(link_word),
    .trap_enter(trap_enter), .trap_ret(trap_ret), .branch_link(branch_link),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    setvl_req = 0; wr_en = 0; trap_enter = 0; trap_ret = 0; branch_link = 0;
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 live", live_word, RST_W);
    chk("R1 save", save_word, RST_W);
    chk("R1 link", link_word, RST_W);
    chk("R1 illegal", 32'(illegal_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (V_OP[i] == 1) begin
        setvl_req = 1; setvl_len = V_ARG[i][REQ_W-1:0];
        #1;
        chk("R3 grant", 32'(setvl_grant), 32'(V_GR[i]));
        step();
        chk("R3 setvl live", live_word, V_EXP[i]);
      end else begin
        wr_en = 1; wr_word = V_ARG[i];
        step();
        chk("R2/R4/R5/R6/R7 write live", live_word, V_EXP[i]);
      end
      chk("R5/R6/R7 illegal", 32'(illegal_o), 32'(V_ILL[i]));
    end

    // R5: pulse lasts one cycle
    wr_en = 1; wr_word = mk(20,3,0,0,0);
    step();
    chk("R5 pulse high", 32'(illegal_o), 32'd1);
    step();
    chk("R5 pulse gone", 32'(illegal_o), 32'd0);
    chk("R5 save untouched", save_word, RST_W);

    // R8: trap enter / return
    trap_enter = 1;
    step();
    chk("R8 enter live", live_word, RST_W);
    chk("R8 enter save", save_word, mk(20,3,1,2,2));
    trap_ret = 1;
    step();
    chk("R8 return live", live_word, mk(20,3,1,2,2));
    chk("R8 return save", save_word, RST_W);

    // R9: link exchange both ways
    branch_link = 1;
    step();
    chk("R9 live", live_word, RST_W);
    chk("R9 link", link_word, mk(20,3,1,2,2));
    branch_link = 1;
    step();
    chk("R9 back live", live_word, mk(20,3,1,2,2));
    chk("R9 back link", link_word, RST_W);

    // R10: trap beats link and write
    trap_enter = 1; branch_link = 1; wr_en = 1; wr_word = mk(0,0,0,0,0);
    step();
    chk("R10 trap wins live", live_word, RST_W);
    chk("R10 trap wins save", save_word, mk(20,3,1,2,2));
    chk("R10 link untouched", link_word, RST_W);
    chk("R10 no illegal", 32'(illegal_o), 32'd0);
    trap_ret = 1;
    step();
    chk("R10 restore", live_word, mk(20,3,1,2,2));

    // R10: link beats write
    branch_link = 1; wr_en = 1; wr_word = mk(10,1,1,0,0);
    step();
    chk("R10 link wins live", live_word, RST_W);
    chk("R10 link wins link", link_word, mk(20,3,1,2,2));
    branch_link = 1;
    step();

    // R10: write beats setvl
    wr_en = 1; wr_word = mk(30,7,2,0,0); setvl_req = 1; setvl_len = 16'd1;
    step();
    chk("R10 write wins", live_word, mk(30,7,2,0,0));

    // R3: request above 64 against MVL 30
    setvl_req = 1; setvl_len = 16'd1000;
    #1;
    chk("R3 big grant", 32'(setvl_grant), 32'd30);
    step();
    chk("R3 big live", live_word, mk(30,30,2,0,0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule